// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address used inside a synchronous burst memory. An access opens when one of two address strobes is seen low on a rising clock edge. One strobe comes from the processor side and the other from the cache controller side. On that edge the block takes the address from the external bus as the first word of a four-word burst. From then on, the bus address is not used. On each later edge where the advance input is low, the block moves the two low address bits to the next burst position. On any other edge it holds them.

The order of a burst comes from a static mode pin. With the pin low, the order is linear: the low bits count up modulo four from the start value. With the pin high, the order is interleaved: the low bits are the start value XORed with a step index that runs 0, 1, 2, 3. After the fourth word the sequence returns to the start word. A new strobe at any point abandons the current burst and loads a fresh address. The mode pin is not registered, so a change on it affects the very next step.

The block has no streaming data path. All of its pins are plain control and address signals, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous reset `rst_n` is low at a rising edge, `addr_o` becomes all zeros and `burst_act` becomes 0.
- R2: When `cpu_stb_n` and `chip_en_n` are both sampled low, `addr_o` equals the sampled `ext_addr` and `burst_act` is 1 after that edge.
- R3: When `ctl_stb_n` is sampled low, `addr_o` equals the sampled `ext_addr` and `burst_act` is 1 after that edge, whatever the state of `chip_en_n`.
- R4: With no start, an edge where `adv_n` is high leaves `addr_o` and `burst_act` unchanged. Within a burst, the bits above the two low ones never change without a start, whatever `ext_addr` does.
- R5: With `linear_n` low, each advance sets the low two bits to (start + n) mod 4, where n is the number of advances since the load.
- R6: With `linear_n` high, each advance sets the low two bits to start XOR (n mod 4).
- R7: The fifth word of a burst, after four advances, equals the start word.
- R8: `cpu_stb_n` low while `chip_en_n` is high has no effect on `addr_o` or `burst_act`.
- R9: A start takes precedence over an advance on the same edge. When both strobes are low together, the processor-side strobe is the one taken and a single load happens.
- R10: `adv_n` low while no burst has started since reset leaves `addr_o` and `burst_act` unchanged.
- R11: `linear_n` is not registered. Each step uses its level at that edge, even partway through a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset to idle, active low |
| ext_addr | input | ADDR_W | External word address captured at a start |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| chip_en_n | input | 1 | Chip enable that qualifies `cpu_stb_n`, active low |
| adv_n | input | 1 | Burst advance, active low |
| linear_n | input | 1 | Static order select: low linear, high interleaved |
| addr_o | output | ADDR_W | Current internal word address |
| burst_act | output | 1 | High once a burst has been loaded since reset |

## Verification
A load and a step can fall on the same edge. This happens when a strobe arrives while `adv_n` is low in the middle of a burst, and the two strobes can also be low together. The bench causes this with directed cycles that drive both strobes and the advance low at once. Random traffic also overlaps them often. On such an edge the result is correct only if `addr_o` equals the new bus address exactly, with no step applied. In the directed cases the bus address is chosen so that a stepped value would differ from it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } start_src_e;

endpackage

// File: rtl/bas_start_arb.sv
module bas_start_arb
  import burst_seq_pkg::*;
(
  input  logic       cpu_stb_n,
  input  logic       ctl_stb_n,
  input  logic       chip_en_n,
  output logic       start,
  output start_src_e src
);

  logic cpu_req;
  logic ctl_req;

  assign cpu_req = ~cpu_stb_n & ~chip_en_n;
  assign ctl_req = ~ctl_stb_n;

  // processor side wins a tie
  always_comb begin
    src = SRC_NONE;
    if (cpu_req)      src = SRC_CPU;
    else if (ctl_req) src = SRC_CTL;
  end

  assign start = (src != SRC_NONE);

endmodule

// File: rtl/bas_offset_gen.sv
module bas_offset_gen
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] base_off,
  input  logic [OFF_W-1:0] step_idx,
  input  order_e           order,
  output logic [OFF_W-1:0] off
);

  logic [OFF_W-1:0] lin_off;
  logic [OFF_W-1:0] xor_off;

  assign lin_off = base_off + step_idx;  // wraps modulo 2**OFF_W
  assign xor_off = base_off ^ step_idx;

  assign off = (order == ORD_XOR) ? xor_off : lin_off;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              linear_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_act
);

  localparam int HI_W = ADDR_W - OFF_W;

  logic              start;
  start_src_e        src;
  order_e            order;
  logic [OFF_W-1:0]  base_q;
  logic [OFF_W-1:0]  idx_q;
  logic [OFF_W-1:0]  idx_nxt;
  logic [OFF_W-1:0]  off_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              act_q;
  logic              step;

  bas_start_arb u_arb (
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .chip_en_n (chip_en_n),
    .start     (start),
    .src       (src)
  );

  // static pin, not registered
  assign order   = linear_n ? ORD_XOR : ORD_LINEAR;
  assign idx_nxt = idx_q + 1'b1;
  assign step    = act_q & ~adv_n & ~start;

  bas_offset_gen #(.OFF_W(OFF_W)) u_off (
    .base_off (base_q),
    .step_idx (idx_nxt),
    .order    (order),
    .off      (off_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
    end else if (start) begin
      addr_q <= ext_addr;
      base_q <= ext_addr[OFF_W-1:0];
      idx_q  <= '0;
      act_q  <= 1'b1;
    end else if (step) begin
      idx_q               <= idx_nxt;
      addr_q[OFF_W-1:0]   <= off_nxt;
    end
  end

  assign addr_o    = addr_q;
  assign burst_act = act_q;

  // R1: reset leaves idle state
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (addr_o == '0 && !burst_act));

  // R2: qualified processor strobe loads the bus address
  p_cpu_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cpu_stb_n && !chip_en_n))
      |-> (addr_o == $past(ext_addr) && burst_act));

  // R3: controller strobe loads regardless of chip enable
  p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!ctl_stb_n))
      |-> (addr_o == $past(ext_addr) && burst_act));

  // R4: no start and no advance holds everything
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(adv_n) && $past(ctl_stb_n) && $past(cpu_stb_n | chip_en_n))
      |-> ($stable(addr_o) && $stable(burst_act)));

  // R4: upper bits only change on a start
  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctl_stb_n) && $past(cpu_stb_n | chip_en_n))
      |-> $stable(addr_o[ADDR_W-1:OFF_W]));

  // R10: advance without a burst changes nothing
  p_idle_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(burst_act) && $past(ctl_stb_n) && $past(cpu_stb_n | chip_en_n))
      |-> (!burst_act && $stable(addr_o)));

  // R9: arbiter never names two sources
  p_one_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !chip_en_n) |-> (src == SRC_CPU));

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed OFF_W");
  end

endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          cpu_stb_n, ctl_stb_n, chip_en_n, adv_n, linear_n;
  logic [AW-1:0] addr_o;
  logic          burst_act;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [AW-1:0] m_addr;
  logic          m_act;
  logic [1:0]    m_base, m_idx;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .OFF_W(2)) dut_i (
    .clk, .rst_n, .ext_addr, .cpu_stb_n, .ctl_stb_n, .chip_en_n,
    .adv_n, .linear_n, .addr_o, .burst_act
  );

  function automatic logic [1:0] exp_off(logic [1:0] b, logic [1:0] n, logic xo);
    return xo ? (b ^ n) : (b + n);
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_addr = '0; m_act = 1'b0; m_base = '0; m_idx = '0;
    end else if ((!cpu_stb_n && !chip_en_n) || !ctl_stb_n) begin
      m_addr = ext_addr; m_base = ext_addr[1:0]; m_idx = '0; m_act = 1'b1;
    end else if (m_act && !adv_n) begin
      m_idx = m_idx + 2'd1;
      m_addr[1:0] = exp_off(m_base, m_idx, linear_n);
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_edge();
    #2;
    n_vec++;
    if (addr_o !== m_addr || burst_act !== m_act) begin
      n_bad++;
      $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
               tag, addr_o, burst_act, m_addr, m_act);
    end
  endtask

  task automatic drive(logic ce, logic cs, logic ct, logic av,
                       logic [AW-1:0] a, logic ln);
    chip_en_n = ce; cpu_stb_n = cs; ctl_stb_n = ct;
    adv_n = av; ext_addr = a; linear_n = ln;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 20'h0, 1'b0);
    #2;
    cycle("R1"); cycle("R1"); cycle("R1");
    rst_n = 1'b1;

    // R10: advance with no burst
    drive(1'b0, 1'b1, 1'b1, 1'b0, 20'h0F0F3, 1'b0);
    cycle("R10"); cycle("R10");
    // R8: processor strobe while chip disabled
    drive(1'b1, 1'b0, 1'b1, 1'b1, 20'h12345, 1'b0);
    cycle("R8");
    // R2: processor load, start low bits 2
    drive(1'b0, 1'b0, 1'b1, 1'b1, 20'h0ABC6, 1'b0);
    cycle("R2");
    // R5 linear steps then R7 wrap
    drive(1'b0, 1'b1, 1'b1, 1'b0, 20'hFFFFF, 1'b0);
    cycle("R5"); cycle("R5"); cycle("R5"); cycle("R7");
    // R4: hold, bus address wiggles
    drive(1'b0, 1'b1, 1'b1, 1'b1, 20'h3C3C3, 1'b0);
    cycle("R4"); cycle("R4");
    // R3: controller load while chip disabled, interleaved
    drive(1'b1, 1'b1, 1'b0, 1'b1, 20'h55551, 1'b1);
    cycle("R3");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b1);
    cycle("R6"); cycle("R6"); cycle("R6"); cycle("R7");
    // R9: both strobes plus advance mid-burst
    cycle("R6");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 20'h00003, 1'b1);
    cycle("R9");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 20'hAAAA2, 1'b0);
    cycle("R9");
    // R11: load base 1 linear, switch to interleaved before first step
    drive(1'b0, 1'b0, 1'b1, 1'b1, 20'h00001, 1'b0);
    cycle("R2");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b1);
    cycle("R11");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b0);
    cycle("R11");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic ln;
      ln = (($urandom % 20) == 0) ? ~linear_n : linear_n;
      drive((($urandom % 10) < 3), (($urandom % 10) != 0),
            (($urandom % 10) != 0), (($urandom % 10) < 4),
            AW'($urandom), ln);
      if (($urandom % 200) == 0) rst_n = 1'b0; else rst_n = 1'b1;
      cycle(!rst_n ? "R1" : (linear_n ? "R6" : "R5"));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule